// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block conditions one active-low external interrupt pin for a CPU. The pin is resynchronised to the core clock. A falling edge, or in level mode also a sustained low level, sets an interrupt latch. The latch drives a pending flag that software can always read. It also drives an interrupt request to the CPU, and that request can be masked.

A small control/status register selects the trigger sensitivity and holds the mask bit. It also has a write-one acknowledge bit that clears the latch. During a debug break the latch is protected: acknowledge writes are ignored unless the separate break-clear-enable input is high. Software can also poll the synchronised pin level directly, apart from the latch.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the pending flag, mask (rd_data[1]), mode (rd_data[0]) and irq_req are all 0, and pin_level is 1 while the pin is high.
- R2: A high-to-low change of the pin sets the pending flag (rd_data[3]). The flag is visible at the third rising clock edge after the pin falls.
- R3: In edge mode (mode = 0), a pin held low does not set the latch again once it has been acknowledged.
- R4: In level mode (mode = 1), an acknowledge while the pin is low leaves the flag set. Once the pin is high again, an acknowledge clears the flag.
- R5: irq_req equals the pending flag ANDed with the inverted mask (mask = 1 blocks the request). The mask has no effect on the flag itself.
- R6: Outside break, a write with wr_data[2] = 1 clears the flag at the next edge. A write with wr_data[2] = 0 leaves the flag unchanged.
- R7: While brk_active = 1 and brk_clr_en = 0, an acknowledge write leaves the flag unchanged.
- R8: While brk_active = 1 and brk_clr_en = 1, an acknowledge write clears the flag, and the flag stays clear after brk_active returns to 0.
- R9: When an acknowledge write and a new falling edge reach the latch in the same cycle, the flag stays set.
- R10: pin_level shows the pin value two rising edges after the pin changes, whatever the latch state.
- R11: A write loads wr_data[0] into the mode bit and wr_data[1] into the mask bit. Both read back on rd_data[0] and rd_data[1], and rd_data[2] reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: [0] mode, [1] mask, [2] acknowledge |
| rd_data | output | 4 | Read data: [0] mode, [1] mask, [2] zero, [3] pending |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows acknowledge to act during break |
| pin_level | output | 1 | Synchronised pin level |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with the default two-stage synchroniser, so the three-edge latch latency is exact and can be checked cycle by cycle. With that fixed latency, the bench sweeps all sixteen combinations of mode, mask, break state and break-clear-enable through the set, acknowledge and break-exit steps. Directed cases then place an acknowledge in the same cycle as a newly detected edge, and hold the pin low across acknowledges in each mode.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_pin_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic [3:0] rd_data,
  input  logic       brk_active,
  input  logic       brk_clr_en,
  output logic       pin_level,
  output logic       irq_req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, latch_q, mask_q, mode_q;
  logic pin_s, fall, set_req, ack_ok;

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign fall    = prev_q & ~pin_s;
  assign set_req = fall | (mode_q & ~pin_s);
  assign ack_ok  = wr_en & wr_data[2] & (~brk_active | brk_clr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
      mask_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], irq_pin_n};
      prev_q <= pin_s;
      if (set_req)     latch_q <= 1'b1;
      else if (ack_ok) latch_q <= 1'b0;
      if (wr_en) begin
        mode_q <= wr_data[0];
        mask_q <= wr_data[1];
      end
    end
  end

  assign rd_data   = {latch_q, 1'b0, mask_q, mode_q};
  assign pin_level = pin_s;
  assign irq_req   = latch_q & ~mask_q;

endmodule

module ext_irq_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_data,
  input logic       brk_active,
  input logic       brk_clr_en,
  input logic       pin_level,
  input logic       flag,
  input logic       mask,
  input logic       mode,
  input logic       irq_req
);

  p_req_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mask) |-> irq_req);

  p_req_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag);

  p_brk_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && brk_active && !brk_clr_en && flag) |=> flag);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !pin_level && flag) |=> flag);

  p_set_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(!pin_level));

  p_clear_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && wr_data[2] && (!brk_active || brk_clr_en)));

endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .brk_active(brk_active), .brk_clr_en(brk_clr_en), .pin_level(pin_level),
  .flag(rd_data[3]), .mask(rd_data[1]), .mode(rd_data[0]), .irq_req(irq_req)
);

// File: tb/tb_ext_irq_latch.sv
module tb_ext_irq_latch;
  logic clk = 0, rst_n = 0, irq_pin_n = 1, wr_en = 0, brk_active = 0, brk_clr_en = 0;
  logic [2:0] wr_data = '0;
  logic [3:0] rd_data;
  logic pin_level, irq_req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_latch dut (.*);

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick(3);
    // R1 reset state
    chk("R1 flag", rd_data[3], 0);
    chk("R1 mask", rd_data[1], 0);
    chk("R1 mode", rd_data[0], 0);
    chk("R1 req", irq_req, 0);
    chk("R1 pin", pin_level, 1);

    // R10 / R2 latency
    irq_pin_n = 0; tick();
    chk("R10 lvl after 1", pin_level, 1);
    tick();
    chk("R10 lvl after 2", pin_level, 0);
    chk("R2 flag not yet", rd_data[3], 0);
    tick();
    chk("R2 flag after 3", rd_data[3], 1);
    chk("R5 req", irq_req, 1);
    // R3 edge mode: ack while low clears, stays clear
    wr(3'b100);
    chk("R3 cleared", rd_data[3], 0);
    tick(4);
    chk("R3 no reset while low", rd_data[3], 0);
    irq_pin_n = 1; tick(3);
    chk("R10 high", pin_level, 1);
    chk("R10 latch independent", rd_data[3], 0);

    // R6 write without ack leaves flag
    irq_pin_n = 0; tick(3); irq_pin_n = 1; tick(3);
    wr(3'b000);
    chk("R6 no ack keeps", rd_data[3], 1);
    wr(3'b100);
    chk("R6 ack clears", rd_data[3], 0);

    // R11 readback
    wr(3'b011);
    chk("R11 mode", rd_data[0], 1);
    chk("R11 mask", rd_data[1], 1);
    chk("R11 bit2", rd_data[2], 0);
    wr(3'b000);

    // R4 level mode
    wr(3'b001);
    irq_pin_n = 0; tick(3);
    chk("R4 set", rd_data[3], 1);
    wr(3'b101);
    chk("R4 ack while low", rd_data[3], 1);
    chk("R4 req again", irq_req, 1);
    irq_pin_n = 1; tick(3);
    chk("R4 still set high", rd_data[3], 1);
    wr(3'b101);
    chk("R4 ack after high", rd_data[3], 0);
    wr(3'b000);

    // R9 ack collides with new edge
    irq_pin_n = 0; tick(3); irq_pin_n = 1; tick(3);
    chk("R9 pre set", rd_data[3], 1);
    irq_pin_n = 0; tick(2);
    wr(3'b100);
    chk("R9 edge wins", rd_data[3], 1);
    irq_pin_n = 1; tick(3);
    wr(3'b100);
    chk("R9 later ack clears", rd_data[3], 0);

    // sweep mode/mask/break/enable
    for (int c = 0; c < 16; c++) begin
      logic md, mk, bk, be, exp;
      md = c[0]; mk = c[1]; bk = c[2]; be = c[3];
      brk_active = 0; irq_pin_n = 1; tick(3);
      wr(3'b100);
      wr({1'b0, mk, md});
      irq_pin_n = 0; tick(3);
      chk("R2 sweep set", rd_data[3], 1);
      chk("R5 sweep req", irq_req, !mk);
      irq_pin_n = 1; tick(3);
      chk("R5 sweep flag kept", rd_data[3], 1);
      brk_active = bk; brk_clr_en = be;
      wr({1'b1, mk, md});
      exp = bk && !be;
      chk(bk ? (be ? "R8 sweep ack" : "R7 sweep ack") : "R6 sweep ack", rd_data[3], exp);
      chk("R5 sweep req after ack", irq_req, exp && !mk);
      brk_active = 0; brk_clr_en = 0; tick(2);
      chk("R8 sweep after break", rd_data[3], exp);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule